// File: doc/BRIEF.md
# Random Word Pacer

This block turns a free-running 32-bit noise input into a paced stream of random words. While its run bit is set, an internal period counter takes one noise sample at the end of every sample period and loads it into an output data register. A status flag then tells software that a fresh word is waiting. A half-rate option doubles the period for systems whose clock is too fast for the normal rate.

The block also records a single-cycle completion pulse from a separate key transfer engine in a second status flag. It raises one interrupt line whenever an unmasked flag is pending. Software reaches the block over a simple register bus. A write strobe with address and data updates configuration and mask. A read strobe with address returns a registered value on the next clock edge. Reading the status register hands back the pending flags and clears them.

Register addresses (word addresses on `addr`): 0 configuration, 1 mask set, 2 mask clear, 3 mask readback, 4 status, 5 random data. In the flag, mask and status fields, bit 0 is the data-ready flag and bit 1 is the key-done flag.

Top module: `rand_word_pacer`

## Requirements
- R1: After reset, configuration, mask, status and data all read as zero and `irq` is low.
- R2: With run bit (configuration bit 0) set and half-rate bit (configuration bit 1) clear, a noise sample is loaded into the data register 84 clocks after the edge that set the run bit and every 84 clocks after that. The data register (address 5) returns the `noise` value present at the loading edge.
- R3: With both run and half-rate bits set, the sample period is 168 clocks.
- R4: Loading a sample sets status bit 0 (data ready).
- R5: A one-cycle pulse on `keyDone` sets status bit 1 (key done).
- R6: `irq` is high exactly while some status bit is set whose mask bit (same position) is set. Masked flags still appear in the status register.
- R7: Writing address 1 sets the mask bits written as 1 and leaves the others unchanged. Writing address 2 clears the mask bits written as 1. Address 3 reads the mask.
- R8: A read of address 4 returns the status held before that edge and clears every flag, so `irq` drops.
- R9: Clearing the run bit stops and zeroes the period counter. After the run bit is set again, the first word arrives a full period after that write.
- R10: When a flag-setting event (sample load or `keyDone`) lands on the same edge as a status read, that flag is set after the edge. The read returns the value held before the edge.
- R11: The data register keeps its value through any number of reads and while the run bit is clear, until the next sample load.
- R12: Address 0 reads back the run and half-rate bits as last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | ADDR_W (4) | Register word address |
| wrData | input | DATA_W (32) | Write data |
| rdData | output | DATA_W (32) | Read data, valid the cycle after `rdEn` |
| noise | input | DATA_W (32) | Noise source word |
| keyDone | input | 1 | One-cycle key transfer completion pulse |
| irq | output | 1 | Interrupt, high while an unmasked flag is pending |

## Verification
The case that needs care is a status read that clears the flags on the same edge that a sample load or a `keyDone` pulse sets one. The bench counts edges from the configuration write that started the counter, so it knows the exact edge of each sample load. It issues a status read timed to that edge, and in a separate step it pairs a read with a `keyDone` pulse. The check requires the read to return the old status and the flag to stay set afterwards, seen both on `irq` and on a follow-up status read.

// File: rtl/rwp_pkg.sv
package rwp_pkg;
  localparam int FLAG_N    = 2;
  localparam int FLAG_DATA = 0;
  localparam int FLAG_KEY  = 1;

  localparam int ADDR_CFG  = 0;
  localparam int ADDR_MSET = 1;
  localparam int ADDR_MCLR = 2;
  localparam int ADDR_MASK = 3;
  localparam int ADDR_STAT = 4;
  localparam int ADDR_DATA = 5;

  typedef struct packed {
    logic cfgWr;
    logic maskSetWr;
    logic maskClrWr;
    logic statusRd;
    logic regRd;
    logic captureNow;
  } strobe_t;
endpackage

// File: rtl/rwp_flag.sv
module rwp_flag (
  input  logic clk,
  input  logic rstN,
  input  logic setEv,
  input  logic clrRd,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rstN)       q <= 1'b0;
    else if (setEv)  q <= 1'b1;   // a new event beats a clearing read
    else if (clrRd)  q <= 1'b0;
  end
endmodule

// File: rtl/rwp_ctrl.sv
module rwp_ctrl #(
  parameter int ADDR_W      = 4,
  parameter int BASE_PERIOD = 84
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              runEn,
  input  logic              halfRate,
  output rwp_pkg::strobe_t  stb
);
  import rwp_pkg::*;

  localparam int CNT_W = $clog2(2 * BASE_PERIOD);
  localparam logic [CNT_W-1:0] LAST_FULL = CNT_W'(BASE_PERIOD - 1);
  localparam logic [CNT_W-1:0] LAST_HALF = CNT_W'(2 * BASE_PERIOD - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] periodLast;
  logic             atEnd;

  assign periodLast = halfRate ? LAST_HALF : LAST_FULL;
  assign atEnd      = (cnt >= periodLast);

  always_ff @(posedge clk) begin
    if (!rstN)       cnt <= '0;
    else if (!runEn) cnt <= '0;
    else if (atEnd)  cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  always_comb begin
    stb            = '0;
    stb.cfgWr      = wrEn && (addr == ADDR_W'(ADDR_CFG));
    stb.maskSetWr  = wrEn && (addr == ADDR_W'(ADDR_MSET));
    stb.maskClrWr  = wrEn && (addr == ADDR_W'(ADDR_MCLR));
    stb.statusRd   = rdEn && (addr == ADDR_W'(ADDR_STAT));
    stb.regRd      = rdEn;
    stb.captureNow = runEn && atEnd;
  end
endmodule

// File: rtl/rwp_dp.sv
module rwp_dp #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  rwp_pkg::strobe_t            stb,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wrData,
  input  logic [DATA_W-1:0]           noise,
  input  logic                        keyDone,
  output logic                        runEn,
  output logic                        halfRate,
  output logic [rwp_pkg::FLAG_N-1:0]  maskQ,
  output logic [DATA_W-1:0]           rdData,
  output logic                        irq
);
  import rwp_pkg::*;

  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] rdNext;
  logic [FLAG_N-1:0] flagEv;
  logic [FLAG_N-1:0] flagQ;
  logic              unusedWr;

  assign unusedWr = ^wrData[DATA_W-1:2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runEn    <= 1'b0;
      halfRate <= 1'b0;
    end else if (stb.cfgWr) begin
      runEn    <= wrData[0];
      halfRate <= wrData[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              maskQ <= '0;
    else if (stb.maskSetWr) maskQ <= maskQ | wrData[FLAG_N-1:0];
    else if (stb.maskClrWr) maskQ <= maskQ & ~wrData[FLAG_N-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)               dataQ <= '0;
    else if (stb.captureNow) dataQ <= noise;
  end

  always_comb begin
    flagEv            = '0;
    flagEv[FLAG_DATA] = stb.captureNow;
    flagEv[FLAG_KEY]  = keyDone;
  end

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    rwp_flag uFlag (
      .clk  (clk),
      .rstN (rstN),
      .setEv(flagEv[i]),
      .clrRd(stb.statusRd),
      .q    (flagQ[i])
    );
  end

  always_comb begin
    rdNext = '0;
    if (addr == ADDR_W'(ADDR_CFG)) begin
      rdNext[0] = runEn;
      rdNext[1] = halfRate;
    end else if (addr == ADDR_W'(ADDR_MASK)) begin
      rdNext[FLAG_N-1:0] = maskQ;
    end else if (addr == ADDR_W'(ADDR_STAT)) begin
      rdNext[FLAG_N-1:0] = flagQ;
    end else if (addr == ADDR_W'(ADDR_DATA)) begin
      rdNext = dataQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdData <= '0;
    else if (stb.regRd) rdData <= rdNext;
  end

  assign irq = |(flagQ & maskQ);
endmodule

// File: rtl/rand_word_pacer.sv
module rand_word_pacer #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int BASE_PERIOD = 84
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] noise,
  input  logic              keyDone,
  output logic              irq
);
  import rwp_pkg::*;

  strobe_t           stb;
  logic              runEn;
  logic              halfRate;
  logic [FLAG_N-1:0] maskQ;

  rwp_ctrl #(.ADDR_W(ADDR_W), .BASE_PERIOD(BASE_PERIOD)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .addr    (addr),
    .runEn   (runEn),
    .halfRate(halfRate),
    .stb     (stb)
  );

  rwp_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .addr    (addr),
    .wrData  (wrData),
    .noise   (noise),
    .keyDone (keyDone),
    .runEn   (runEn),
    .halfRate(halfRate),
    .maskQ   (maskQ),
    .rdData  (rdData),
    .irq     (irq)
  );
endmodule

// File: rtl/rwp_chk.sv
module rwp_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic              keyDone,
  input logic              irq,
  input logic              captureNow,
  input logic              runEn,
  input logic [1:0]        maskVec
);
  import rwp_pkg::*;

  // R8
  status_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_W'(ADDR_STAT) && !keyDone && !captureNow) |=> !irq);

  // R10
  key_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (keyDone && maskVec[FLAG_KEY]) |=> irq);

  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !rdEn && !wrEn) |=> irq);

  // R9
  stop_no_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> !captureNow);

  // R2
  single_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    captureNow |=> !captureNow);
endmodule

bind rand_word_pacer rwp_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .rdEn      (rdEn),
  .addr      (addr),
  .keyDone   (keyDone),
  .irq       (irq),
  .captureNow(stb.captureNow),
  .runEn     (runEn),
  .maskVec   (maskQ)
);

// File: tb/sim_rand_word_pacer.sv
`timescale 1ns/1ps
module sim_rand_word_pacer;
  localparam int P = 84;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] noise = '0;
  logic        keyDone = 1'b0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rand_word_pacer u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .noise(noise), .keyDone(keyDone), .irq(irq)
  );

  // fields: [20] write, [19:16] address, [15:8] data, [7:0] expected read
  localparam logic [20:0] VEC [12] = '{
    {1'b1, 4'd1, 8'h03, 8'h00},
    {1'b0, 4'd3, 8'h00, 8'h03},
    {1'b1, 4'd2, 8'h01, 8'h00},
    {1'b0, 4'd3, 8'h00, 8'h02},
    {1'b1, 4'd1, 8'h01, 8'h00},
    {1'b0, 4'd3, 8'h00, 8'h03},
    {1'b1, 4'd2, 8'h03, 8'h00},
    {1'b0, 4'd3, 8'h00, 8'h00},
    {1'b1, 4'd0, 8'h02, 8'h00},
    {1'b0, 4'd0, 8'h00, 8'h02},
    {1'b1, 4'd0, 8'h00, 8'h00},
    {1'b0, 4'd0, 8'h00, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    addr = 4'(a); wrData = d; wrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    addr = 4'(a); rdEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rdEn = 1'b0;
    v = rdData;
  endtask

  task automatic idleTo(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic waitIrq(input int limit, output int at);
    at = -1;
    for (int k = 0; k < limit; k++) begin
      if (irq) begin
        at = cyc;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    int w, t;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(0, v); chk("R1 cfg", v, 32'h0);
    rd(3, v); chk("R1 mask", v, 32'h0);
    rd(4, v); chk("R1 status", v, 32'h0);
    rd(5, v); chk("R1 data", v, 32'h0);

    // R7 / R12 vector walk
    foreach (VEC[i]) begin
      if (VEC[i][20]) wr(int'(VEC[i][19:16]), {24'b0, VEC[i][15:8]});
      else begin
        rd(int'(VEC[i][19:16]), v);
        chk(VEC[i][19:16] == 4'd0 ? "R12 cfg readback" : "R7 mask readback",
            v, {24'b0, VEC[i][7:0]});
      end
    end

    // R5 / R6 masked key pulse
    keyDone = 1'b1; @(posedge clk); @(negedge clk); keyDone = 1'b0;
    chk("R6 masked irq", {31'b0, irq}, 32'h0);
    rd(4, v); chk("R5 key flag", v, 32'h2);
    rd(4, v); chk("R8 status cleared", v, 32'h0);
    wr(1, 32'h2);
    keyDone = 1'b1; @(posedge clk); @(negedge clk); keyDone = 1'b0;
    chk("R6 unmasked irq", {31'b0, irq}, 32'h1);
    rd(4, v); chk("R5 key read", v, 32'h2);
    chk("R8 irq after read", {31'b0, irq}, 32'h0);

    // R2 / R4 full rate
    wr(1, 32'h1);
    noise = 32'hA5A5_0F0F;
    wr(0, 32'h1); w = cyc;
    waitIrq(300, t); chk("R2 first word edge", t, w + P);
    rd(5, v); chk("R2 data value", v, 32'hA5A5_0F0F);
    rd(5, v); chk("R11 data held after read", v, 32'hA5A5_0F0F);
    rd(4, v); chk("R4 ready flag", v, 32'h1);
    chk("R8 irq dropped", {31'b0, irq}, 32'h0);
    noise = 32'h1234_5678;
    waitIrq(300, t); chk("R2 second word edge", t, w + 2 * P);
    rd(5, v); chk("R2 second data", v, 32'h1234_5678);
    rd(4, v);

    // R10 read on the load edge
    idleTo(w + 3 * P - 1);
    rd(4, v); chk("R10 read returns old", v, 32'h0);
    chk("R10 irq after collision", {31'b0, irq}, 32'h1);
    rd(4, v); chk("R10 flag kept", v, 32'h1);
    addr = 4'd4; rdEn = 1'b1; keyDone = 1'b1;
    @(posedge clk); @(negedge clk);
    rdEn = 1'b0; keyDone = 1'b0;
    chk("R10 key read old", rdData, 32'h0);
    rd(4, v); chk("R10 key flag kept", v & 32'h2, 32'h2);

    // R9 / R11 stopped
    wr(0, 32'h0);
    rd(4, v);
    rd(5, v);
    noise = 32'hDEAD_BEEF;
    repeat (200) @(negedge clk);
    chk("R9 no irq while stopped", {31'b0, irq}, 32'h0);
    rd(5, v); chk("R11 data held while stopped", v, 32'h1234_5678);

    // R3 half rate
    wr(0, 32'h3); w = cyc;
    waitIrq(400, t); chk("R3 half-rate edge", t, w + 2 * P);
    rd(5, v); chk("R3 half-rate data", v, 32'hDEAD_BEEF);

    // R9 restart from zero
    wr(0, 32'h0);
    rd(4, v);
    wr(0, 32'h1);
    repeat (50) @(negedge clk);
    wr(0, 32'h0);
    repeat (10) @(negedge clk);
    wr(0, 32'h1); w = cyc;
    waitIrq(300, t); chk("R9 restart full period", t, w + P);

    finishRun();
  end
endmodule